// File: doc/BRIEF.md
# Debug Stall and Exception Trap Controller

This block keeps the run-control state of a processor debug unit. A debug host reaches four small registers through a plain read/write port. They are a mode register, a control register, a per-cause trap-enable mask and a sticky trap-reason record. The control register has a stall bit and a reset bit. The block turns them into a registered processor-stall output and a one-clock system-reset pulse. The pulse fires only when the host clears a reset bit that was set.

The core reports exceptions as a one-hot event vector. When the enable bit for the reported cause is set, the block diverts the exception into debug. It records the cause in the reason register, sets the stall bit and signals that debug has absorbed the exception. Instruction-fetch events and an external watchpoint-break input can also raise a debug stop. Fetch events do this only while single-step mode is on. A debug stop is suppressed while the reset bit is held or the unit is switched off.

Top module: `dbg_runctl`

## Requirements
- R1: After synchronous reset, every output is 0 and every register reads back as 0.
- R2: A host write to the control register (address 1) replaces its stall bit (bit 0) and reset bit (bit 1). From the cycle after the write, `stall_o` equals the stall bit, unless R3 applies.
- R3: While the hold-off bit (bit 1) of the mode register (address 0) is 1, `stall_o` is 0 whatever the stall bit holds.
- R4: `sys_rst_o` is a pulse one clock wide. It is due in the cycle after a write that takes the reset bit from 1 to 0. Setting the bit or keeping it high gives no pulse.
- R5: `dbg_stop_o` stays 0 while either of two bits is 1: the control reset bit, or the unit-off bit (bit 2) of the mode register.
- R6: There are thirteen cause bits. In order: 0 bus error, 1 alignment, 2 illegal instruction, 3 system call, 4 trap, 5 range, 6 data page fault, 7 instruction page fault, 8 data TLB miss, 9 instruction TLB miss, 10 tick timer, 11 external interrupt, 12 reset. An event on cause i while bit i of the trap-enable register (address 2) is set does three things: it ORs bit i into the reason register (address 3), sets the stall bit, and drives `exc_absorbed_o` high in the next cycle.
- R7: An event on a cause whose enable bit is clear leaves the reason register and the stall bit unchanged, and `exc_absorbed_o` stays 0.
- R8: With the single-step bit (bit 0) of the mode register set, each `fetch_evt` makes `dbg_stop_o` high in the next cycle. Each `wp_break` does the same regardless of that bit. R5 has precedence.
- R9: Reason bits are sticky. They accumulate over trapped events until the host writes the reason register, which replaces its contents.
- R10: A host write to the reason or control register wins over a trap update of that register in the same cycle.
- R11: A read or write to an address above 3 sets `host_err` in the next cycle and changes no register.
- R12: A read returns the addressed register, zero-extended, on `host_rdata` in the next cycle. With no read, `host_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | DATA_W | Write data |
| exc_evt | input | N_CAUSE | One-hot exception event |
| fetch_evt | input | 1 | Instruction-fetch event |
| wp_break | input | 1 | Watchpoint break request |
| host_rdata | output | DATA_W | Read data, one cycle after the read |
| host_err | output | 1 | Bad-address flag, one cycle after the access |
| stall_o | output | 1 | Processor stall |
| sys_rst_o | output | 1 | One-clock system-reset pulse |
| exc_absorbed_o | output | 1 | Exception diverted into debug |
| dbg_stop_o | output | 1 | Debug stop from single step or watchpoint |

## Verification
Every output is registered, so every result is due one clock after the edge that samples its stimulus. This covers the stall level, the reset pulse, the absorbed flag, the stop flag, read data and the error flag. Register contents change at that same edge. Their effect shows one cycle later through a read, or at once through `stall_o`. The bench drives inputs after the falling edge and updates its behavioural model at the rising edge. It compares all six outputs against the model at the following falling edge. The directed checks sample at that same point after each stimulus cycle.

// File: rtl/dbgrc_pkg.sv
`timescale 1ns/1ps
package dbgrc_pkg;
  // register addresses
  localparam int A_MODE   = 0;
  localparam int A_CTRL   = 1;
  localparam int A_TRAPEN = 2;
  localparam int A_REASON = 3;
  localparam int NUM_REGS = 4;

  // mode register fields
  localparam int MODE_W    = 3;
  localparam int MODE_STEP = 0;
  localparam int MODE_HOLD = 1;
  localparam int MODE_OFF  = 2;

  // control register fields
  localparam int CTRL_W     = 2;
  localparam int CTRL_STALL = 0;
  localparam int CTRL_RST   = 1;

  // exception cause bit positions
  localparam int CS_BUSERR  = 0;
  localparam int CS_ALIGN   = 1;
  localparam int CS_ILLEGAL = 2;
  localparam int CS_SYSCALL = 3;
  localparam int CS_TRAP    = 4;
  localparam int CS_RANGE   = 5;
  localparam int CS_DPAGE   = 6;
  localparam int CS_IPAGE   = 7;
  localparam int CS_DTLB    = 8;
  localparam int CS_ITLB    = 9;
  localparam int CS_TICK    = 10;
  localparam int CS_EXTINT  = 11;
  localparam int CS_RESET   = 12;
endpackage

// File: rtl/dbgrc_trap.sv
`timescale 1ns/1ps
module dbgrc_trap #(
  parameter int N_CAUSE = 13
) (
  input  logic [N_CAUSE-1:0] exc_evt,
  input  logic [N_CAUSE-1:0] trap_en,
  output logic [N_CAUSE-1:0] trap_hit,
  output logic               any_hit
);
  // per-cause gating of exception events into debug
  for (genvar i = 0; i < N_CAUSE; i++) begin : g_cause
    assign trap_hit[i] = exc_evt[i] & trap_en[i];
  end

  assign any_hit = |trap_hit;
endmodule

// File: rtl/dbgrc_regs.sv
`timescale 1ns/1ps
module dbgrc_regs
  import dbgrc_pkg::*;
#(
  parameter int N_CAUSE = 13,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic [N_CAUSE-1:0] trap_hit,
  input  logic               any_hit,
  output logic [MODE_W-1:0]  mode_q,
  output logic [MODE_W-1:0]  mode_d,
  output logic [CTRL_W-1:0]  ctrl_q,
  output logic [CTRL_W-1:0]  ctrl_d,
  output logic [N_CAUSE-1:0] trap_en_q,
  output logic [N_CAUSE-1:0] reason_q,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               err_o
);
  logic               addr_ok;
  logic               sel_mode, sel_ctrl, sel_en, sel_reason;
  logic [N_CAUSE-1:0] trap_en_d, reason_d;
  logic [DATA_W-1:0]  rd_val;
  logic               unused_hi;

  assign addr_ok    = ({1'b0, host_addr} < (ADDR_W+1)'(NUM_REGS));
  assign sel_mode   = host_wr && (host_addr == ADDR_W'(A_MODE));
  assign sel_ctrl   = host_wr && (host_addr == ADDR_W'(A_CTRL));
  assign sel_en     = host_wr && (host_addr == ADDR_W'(A_TRAPEN));
  assign sel_reason = host_wr && (host_addr == ADDR_W'(A_REASON));
  assign unused_hi  = ^host_wdata[DATA_W-1:N_CAUSE];

  // next-state: host writes override trap-driven updates
  always_comb begin
    mode_d    = sel_mode ? host_wdata[MODE_W-1:0] : mode_q;
    trap_en_d = sel_en ? host_wdata[N_CAUSE-1:0] : trap_en_q;
    reason_d  = sel_reason ? host_wdata[N_CAUSE-1:0] : (reason_q | trap_hit);
    ctrl_d    = ctrl_q;
    if (any_hit)
      ctrl_d[CTRL_STALL] = 1'b1;
    if (sel_ctrl)
      ctrl_d = host_wdata[CTRL_W-1:0];
  end

  // read mux uses the pre-write contents
  always_comb begin
    rd_val = '0;
    case (host_addr)
      ADDR_W'(A_MODE):   rd_val[MODE_W-1:0]  = mode_q;
      ADDR_W'(A_CTRL):   rd_val[CTRL_W-1:0]  = ctrl_q;
      ADDR_W'(A_TRAPEN): rd_val[N_CAUSE-1:0] = trap_en_q;
      ADDR_W'(A_REASON): rd_val[N_CAUSE-1:0] = reason_q;
      default:           rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      ctrl_q    <= '0;
      trap_en_q <= '0;
      reason_q  <= '0;
      rdata_o   <= '0;
      err_o     <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      ctrl_q    <= ctrl_d;
      trap_en_q <= trap_en_d;
      reason_q  <= reason_d;
      rdata_o   <= host_rd ? rd_val : '0;
      err_o     <= (host_wr | host_rd) & ~addr_ok;
    end
  end
endmodule

// File: rtl/dbgrc_outs.sv
`timescale 1ns/1ps
module dbgrc_outs
  import dbgrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_q,
  input  logic [MODE_W-1:0] mode_d,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic [CTRL_W-1:0] ctrl_d,
  input  logic              any_hit,
  input  logic              fetch_evt,
  input  logic              wp_break,
  output logic              stall_o,
  output logic              sys_rst_o,
  output logic              absorbed_o,
  output logic              stop_o
);
  logic quiet;
  logic unused_fields;

  assign unused_fields = ^{mode_q[MODE_HOLD], mode_d[MODE_STEP], mode_d[MODE_OFF],
                           ctrl_q[CTRL_STALL]};
  // stops are muted while the core is held in reset or the unit is off
  assign quiet = ctrl_q[CTRL_RST] | mode_q[MODE_OFF];

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_o    <= 1'b0;
      sys_rst_o  <= 1'b0;
      absorbed_o <= 1'b0;
      stop_o     <= 1'b0;
    end else begin
      stall_o    <= ctrl_d[CTRL_STALL] & ~mode_d[MODE_HOLD];
      sys_rst_o  <= ctrl_q[CTRL_RST] & ~ctrl_d[CTRL_RST];
      absorbed_o <= any_hit;
      stop_o     <= ~quiet & ((fetch_evt & mode_q[MODE_STEP]) | wp_break);
    end
  end
endmodule

// File: rtl/dbg_runctl.sv
`timescale 1ns/1ps
module dbg_runctl
  import dbgrc_pkg::*;
#(
  parameter int N_CAUSE = 13,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic [N_CAUSE-1:0] exc_evt,
  input  logic               fetch_evt,
  input  logic               wp_break,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_err,
  output logic               stall_o,
  output logic               sys_rst_o,
  output logic               exc_absorbed_o,
  output logic               dbg_stop_o
);
  logic [MODE_W-1:0]  mode_q, mode_d;
  logic [CTRL_W-1:0]  ctrl_q, ctrl_d;
  logic [N_CAUSE-1:0] trap_en_q, reason_q, trap_hit;
  logic               any_hit;

  dbgrc_trap #(.N_CAUSE(N_CAUSE)) u_trap (
    .exc_evt (exc_evt),
    .trap_en (trap_en_q),
    .trap_hit(trap_hit),
    .any_hit (any_hit)
  );

  dbgrc_regs #(.N_CAUSE(N_CAUSE), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .trap_hit  (trap_hit),
    .any_hit   (any_hit),
    .mode_q    (mode_q),
    .mode_d    (mode_d),
    .ctrl_q    (ctrl_q),
    .ctrl_d    (ctrl_d),
    .trap_en_q (trap_en_q),
    .reason_q  (reason_q),
    .rdata_o   (host_rdata),
    .err_o     (host_err)
  );

  dbgrc_outs u_outs (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (mode_q),
    .mode_d    (mode_d),
    .ctrl_q    (ctrl_q),
    .ctrl_d    (ctrl_d),
    .any_hit   (any_hit),
    .fetch_evt (fetch_evt),
    .wp_break  (wp_break),
    .stall_o   (stall_o),
    .sys_rst_o (sys_rst_o),
    .absorbed_o(exc_absorbed_o),
    .stop_o    (dbg_stop_o)
  );
endmodule

// File: rtl/dbgrc_checker.sv
`timescale 1ns/1ps
module dbgrc_checker
  import dbgrc_pkg::*;
#(
  parameter int N_CAUSE = 13,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               host_wr,
  input logic [ADDR_W-1:0]  host_addr,
  input logic [MODE_W-1:0]  mode_q,
  input logic [CTRL_W-1:0]  ctrl_q,
  input logic [N_CAUSE-1:0] trap_en_q,
  input logic [N_CAUSE-1:0] reason_q,
  input logic               stall_o,
  input logic               sys_rst_o,
  input logic               dbg_stop_o,
  input logic               host_err
);
  AST_STALL_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> ctrl_q[CTRL_STALL]); // R2

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    mode_q[MODE_HOLD] |-> !stall_o); // R3

  AST_RST_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |=> !sys_rst_o); // R4

  AST_RST_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> ($past(ctrl_q[CTRL_RST]) && !ctrl_q[CTRL_RST])); // R4

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    dbg_stop_o |-> ($past(!ctrl_q[CTRL_RST]) && $past(!mode_q[MODE_OFF]))); // R5

  AST_REASON_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(host_wr && (host_addr == ADDR_W'(A_REASON)))
      |-> ((reason_q & $past(reason_q)) == $past(reason_q))); // R9

  AST_BAD_ADDR_NOCHANGE: assert property (@(posedge clk) disable iff (rst)
    host_err |-> ($stable(mode_q) && $stable(trap_en_q))); // R11
endmodule

bind dbg_runctl dbgrc_checker #(.N_CAUSE(N_CAUSE), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .mode_q    (mode_q),
  .ctrl_q    (ctrl_q),
  .trap_en_q (trap_en_q),
  .reason_q  (reason_q),
  .stall_o   (stall_o),
  .sys_rst_o (sys_rst_o),
  .dbg_stop_o(dbg_stop_o),
  .host_err  (host_err)
);

// File: tb/dbg_runctl_test.sv
`timescale 1ns/1ps
module dbg_runctl_test;
  localparam int NC = 13;
  localparam int DW = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 1'b0, host_rd = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [NC-1:0] exc_evt = '0;
  logic          fetch_evt = 1'b0, wp_break = 1'b0;
  logic [DW-1:0] host_rdata;
  logic          host_err, stall_o, sys_rst_o, exc_absorbed_o, dbg_stop_o;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbg_runctl #(.N_CAUSE(NC), .DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .exc_evt(exc_evt),
    .fetch_evt(fetch_evt), .wp_break(wp_break), .host_rdata(host_rdata),
    .host_err(host_err), .stall_o(stall_o), .sys_rst_o(sys_rst_o),
    .exc_absorbed_o(exc_absorbed_o), .dbg_stop_o(dbg_stop_o)
  );

  // behavioural reference model
  logic [2:0]    m_mode, n_mode;
  logic [1:0]    m_ctrl, n_ctrl;
  logic [NC-1:0] m_en, m_reason, n_reason, hit;
  logic [DW-1:0] e_rdata;
  logic          e_err, e_stall, e_rst, e_abs, e_stop;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_ctrl = 0; m_en = 0; m_reason = 0;
      e_rdata = 0; e_err = 0; e_stall = 0; e_rst = 0; e_abs = 0; e_stop = 0;
    end else begin
      hit = exc_evt & m_en;
      e_rdata = 0;
      if (host_rd) begin
        if (host_addr == 0) e_rdata = DW'(m_mode);
        else if (host_addr == 1) e_rdata = DW'(m_ctrl);
        else if (host_addr == 2) e_rdata = DW'(m_en);
        else if (host_addr == 3) e_rdata = DW'(m_reason);
      end
      e_err  = (host_rd || host_wr) && (host_addr > 3);
      e_abs  = (hit != 0);
      e_stop = !m_ctrl[1] && !m_mode[2] && ((fetch_evt && m_mode[0]) || wp_break);
      n_mode = m_mode;
      n_ctrl = m_ctrl;
      n_reason = m_reason | hit;
      if (hit != 0) n_ctrl[0] = 1'b1;
      if (host_wr) begin
        if (host_addr == 0) n_mode = host_wdata[2:0];
        if (host_addr == 1) n_ctrl = host_wdata[1:0];
        if (host_addr == 2) m_en = host_wdata[NC-1:0];
        if (host_addr == 3) n_reason = host_wdata[NC-1:0];
      end
      e_rst   = m_ctrl[1] && !n_ctrl[1];
      e_stall = n_ctrl[0] && !n_mode[1];
      m_mode = n_mode; m_ctrl = n_ctrl; m_reason = n_reason;
    end
  end

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every output with the model on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      cmp(32'(host_rdata), 32'(e_rdata), "R12 rdata vs model");
      cmp(32'(host_err), 32'(e_err), "R11 err vs model");
      cmp(32'(stall_o), 32'(e_stall), "R2 stall vs model");
      cmp(32'(sys_rst_o), 32'(e_rst), "R4 sys_rst vs model");
      cmp(32'(exc_absorbed_o), 32'(e_abs), "R6 absorbed vs model");
      cmp(32'(dbg_stop_o), 32'(e_stop), "R8 stop vs model");
    end
  end

  task automatic cyc(input logic wr, input logic rd, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic [NC-1:0] e,
                     input logic f, input logic w);
    host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
    exc_evt = e; fetch_evt = f; wp_break = w;
    @(posedge clk);
    @(negedge clk);
    host_wr = 0; host_rd = 0; exc_evt = 0; fetch_evt = 0; wp_break = 0;
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1, 0, a, d, '0, 0, 0);
  endtask

  task automatic rd_reg(input logic [AW-1:0] a);
    cyc(0, 1, a, '0, '0, 0, 0);
  endtask

  task automatic evt(input int cause);
    cyc(0, 0, '0, '0, NC'(1) << cause, 0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    cmp(32'(stall_o), 0, "R1 stall after reset");
    cmp(32'(sys_rst_o), 0, "R1 sys_rst after reset");
    for (int a = 0; a < 4; a++) begin
      rd_reg(AW'(a));
      cmp(32'(host_rdata), 0, "R1 register after reset");
    end

    // R2 stall bit, R12 read back
    wr_reg(1, 16'h0001);
    cmp(32'(stall_o), 1, "R2 stall follows bit");
    rd_reg(1);
    cmp(32'(host_rdata), 1, "R12 control read");

    // R3 hold-off
    wr_reg(0, 16'h0002);
    cmp(32'(stall_o), 0, "R3 hold-off forces stall low");
    wr_reg(0, 16'h0000);
    cmp(32'(stall_o), 1, "R3 stall returns after hold-off");
    wr_reg(1, 16'h0000);
    cmp(32'(stall_o), 0, "R2 stall cleared");

    // R4 reset pulse on falling bit
    wr_reg(1, 16'h0002);
    cmp(32'(sys_rst_o), 0, "R4 no pulse on set");
    cyc(0, 0, '0, '0, '0, 0, 0);
    cmp(32'(sys_rst_o), 0, "R4 no pulse while held");
    wr_reg(1, 16'h0000);
    cmp(32'(sys_rst_o), 1, "R4 pulse on clear");
    cyc(0, 0, '0, '0, '0, 0, 0);
    cmp(32'(sys_rst_o), 0, "R4 pulse one clock");

    // R6, R7 trapping (enable system call=3, instruction TLB miss=9)
    wr_reg(2, 16'h0208);
    evt(5);
    cmp(32'(exc_absorbed_o), 0, "R7 disabled cause not absorbed");
    cmp(32'(stall_o), 0, "R7 disabled cause no stall");
    rd_reg(3);
    cmp(32'(host_rdata), 0, "R7 reason unchanged");
    evt(3);
    cmp(32'(exc_absorbed_o), 1, "R6 absorbed");
    cmp(32'(stall_o), 1, "R6 stall on trap");
    rd_reg(3);
    cmp(32'(host_rdata), 32'h8, "R6 reason bit");
    evt(9);
    rd_reg(3);
    cmp(32'(host_rdata), 32'h208, "R9 reason accumulates");
    wr_reg(1, 16'h0000);

    // R10 host write wins
    cyc(1, 0, 3, 16'h0001, NC'(1) << 3, 0, 0);
    rd_reg(3);
    cmp(32'(host_rdata), 1, "R10 reason write beats trap");
    cyc(1, 0, 1, 16'h0000, NC'(1) << 9, 0, 0);
    cmp(32'(stall_o), 0, "R10 control write beats trap stall");
    rd_reg(3);
    cmp(32'(host_rdata), 32'h201, "R9 trap still recorded");

    // R8 single step and watchpoint, R5 suppression
    wr_reg(0, 16'h0001);
    cyc(0, 0, '0, '0, '0, 1, 0);
    cmp(32'(dbg_stop_o), 1, "R8 step stop on fetch");
    cyc(0, 0, '0, '0, '0, 0, 0);
    cmp(32'(dbg_stop_o), 0, "R8 no stop without fetch");
    wr_reg(0, 16'h0000);
    cyc(0, 0, '0, '0, '0, 1, 0);
    cmp(32'(dbg_stop_o), 0, "R8 fetch without step");
    cyc(0, 0, '0, '0, '0, 0, 1);
    cmp(32'(dbg_stop_o), 1, "R8 watchpoint stop");
    wr_reg(0, 16'h0005);
    cyc(0, 0, '0, '0, '0, 1, 1);
    cmp(32'(dbg_stop_o), 0, "R5 unit off mutes stop");
    wr_reg(0, 16'h0001);
    wr_reg(1, 16'h0002);
    cyc(0, 0, '0, '0, '0, 1, 1);
    cmp(32'(dbg_stop_o), 0, "R5 reset bit mutes stop");
    wr_reg(1, 16'h0000);
    cmp(32'(sys_rst_o), 1, "R4 pulse after held reset");

    // R11 bad address
    wr_reg(5, 16'hFFFF);
    cmp(32'(host_err), 1, "R11 bad write flagged");
    rd_reg(0);
    cmp(32'(host_rdata), 1, "R11 mode unchanged");
    cmp(32'(host_err), 0, "R11 good read no error");
    rd_reg(2);
    cmp(32'(host_rdata), 32'h208, "R11 enables unchanged");
    rd_reg(7);
    cmp(32'(host_err), 1, "R11 bad read flagged");
    cmp(32'(host_rdata), 0, "R11 bad read data zero");

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [NC-1:0] e;
      e = ($urandom % 3 == 0) ? (NC'(1) << ($urandom % NC)) : '0;
      cyc(($urandom % 4) == 0, ($urandom % 3) == 0, AW'($urandom % 8),
          DW'($urandom), e, ($urandom % 2) == 0, ($urandom % 6) == 0);
    end
    finish_run();
  end
endmodule